// File: doc/BRIEF.md
# Armable Sleep Wake-Up Timer

This block is a one-shot wake-up timer for a low-power controller. Software writes a small control register: a 3-bit period, a 1-bit unit select and an arm bit. An arm write presets a down-counter with the period multiplied by the selected unit, expressed in ticks of a slow real-time-clock timebase (nominally 2 Hz). The counter advances only while the system mode is one of the two sleep-type modes. When it runs out it issues a single-cycle wake request and then returns to the disarmed state.

A power-fail (brownout) mode holds the timer cleared, and a return from a sleep-type mode to the active mode also clears it. Arming has to happen some real-time-clock ticks before sleep is entered. A ready flag shows that this lead time has passed, and a sticky flag records entry into sleep before the lead time was met.

Top module: `wake_timer`

## Requirements
- R1: After synchronous reset, `armed`, `wake`, `sleep_ok` and `lead_violation` are 0, the period register holds 3'b001 and the unit select holds 0.
- R2: A write with `wr_arm`=1 presets the counter from the period and unit values held in the registers before that write. The period and unit carried by the same write are stored and apply only to later arm writes.
- R3: The preset is period × unit ticks. Unit select 0 gives SHORT_TICKS ticks per unit (5, i.e. 2.5 s at 2 Hz) and unit select 1 gives LONG_TICKS ticks per unit (120, i.e. 1 min). `wake` rises in the cycle after the N-th counted tick, where N is the preset.
- R4: Ticks are counted only while `mode` is 2'b10 (sleep) or 2'b11 (display-only). Ticks arriving in 2'b00 (active) leave the count unchanged.
- R5: A preset of 0 (period 0) raises `wake` after the first tick counted in a sleep-type mode.
- R6: `wake` is high for exactly one cycle, and `armed` falls in that same cycle. No further `wake` occurs until the timer is armed again.
- R7: While `mode` is 2'b01 (brownout), the timer is cleared and disarmed on every cycle, and arm writes have no effect.
- R8: A change of `mode` from a sleep-type value to 2'b00 (active) clears and disarms the timer.
- R9: `sleep_ok` rises in the cycle after the LEAD_TICKS-th tick since the last arm (3 by default). It stays high while armed and goes low once the timer is disarmed.
- R10: When `mode` changes from a non-sleep value to a sleep-type value while armed and `sleep_ok` is 0, `lead_violation` is set. It stays set until the next accepted arm write.
- R11: An arm write while already armed reloads the counter and restarts the lead-time count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_arm | input | 1 | Arm bit of the write |
| wr_period | input | 3 | Period field of the write |
| wr_unit | input | 1 | Unit select of the write (1 = long) |
| mode | input | 2 | 00 active, 01 brownout, 10 sleep, 11 display-only |
| rtc_tick | input | 1 | One-cycle timebase tick |
| wake | output | 1 | One-cycle wake request |
| armed | output | 1 | Timer armed |
| sleep_ok | output | 1 | Lead time since arming satisfied |
| lead_violation | output | 1 | Sleep entered before lead time (sticky) |

## Verification
The bench builds the block with SHORT_TICKS=5, LEAD_TICKS=3 and LONG_TICKS reduced to 12. With these values a long-unit timeout of 60 ticks and the full 35-tick short range fit in a short run. It also still separates the two units from the lead window. Expected wake ticks are pushed into a scoreboard. The cases covered are the reset period, the use of the old register values at arm time, both units, period zero, interruption by a return to active mode, brownout, a lead-time violation and a re-arm while sleeping.

// File: rtl/wake_timer_pkg.sv
package wake_timer_pkg;

    typedef enum logic [1:0] {
        MODE_ACTIVE   = 2'b00,
        MODE_BROWNOUT = 2'b01,
        MODE_SLEEP    = 2'b10,
        MODE_DISPLAY  = 2'b11
    } mode_e;

    localparam int PERIOD_W = 3;
    localparam logic [PERIOD_W-1:0] PERIOD_RST = 3'b001;

    typedef struct packed {
        logic [PERIOD_W-1:0] period;
        logic                unit;
    } wake_cfg_t;

    function automatic logic is_sleep_type(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic int unsigned preset_ticks(input wake_cfg_t cfg,
                                                 input int unsigned short_t,
                                                 input int unsigned long_t);
        int unsigned u;
        u = cfg.unit ? long_t : short_t;
        return int'(cfg.period) * u;
    endfunction

endpackage

// File: rtl/wake_cfg_reg.sv
module wake_cfg_reg
    import wake_timer_pkg::*;
#(
    parameter int SHORT_TICKS = 5,
    parameter int LONG_TICKS  = 120,
    parameter int CNT_W       = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_arm,
    input  logic                arm_allow,
    input  wake_cfg_t           wr_cfg,
    output logic                load,
    output logic [CNT_W-1:0]    load_val
);
    wake_cfg_t cfg_q;
    int unsigned preset;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.period <= PERIOD_RST;
            cfg_q.unit   <= 1'b0;
        end else if (wr_en) begin
            cfg_q <= wr_cfg;
        end
    end

    // Preset is taken from the values held before this write.
    always_comb begin
        preset   = preset_ticks(cfg_q, SHORT_TICKS, LONG_TICKS);
        load_val = preset[CNT_W-1:0];
        load     = wr_en && wr_arm && arm_allow;
    end
endmodule

// File: rtl/wake_countdown.sv
module wake_countdown #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             armed,
    output logic             wake
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            armed <= 1'b0;
            wake  <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            armed <= 1'b1;
            wake  <= 1'b0;
        end else if (armed && step) begin
            if (cnt_q <= CNT_W'(1)) begin
                cnt_q <= '0;
                armed <= 1'b0;
                wake  <= 1'b1;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
                wake  <= 1'b0;
            end
        end else begin
            wake <= 1'b0;
        end
    end
endmodule

// File: rtl/wake_lead_guard.sv
module wake_lead_guard #(
    parameter int LEAD_TICKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic load,
    input  logic armed,
    input  logic tick,
    input  logic enter_sleep,
    output logic sleep_ok,
    output logic lead_violation
);
    localparam int LW = $clog2(LEAD_TICKS + 1);
    logic [LW-1:0] lead_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lead_q         <= '0;
            sleep_ok       <= 1'b0;
            lead_violation <= 1'b0;
        end else if (load) begin
            lead_q         <= '0;
            sleep_ok       <= 1'b0;
            lead_violation <= 1'b0;
        end else begin
            if (clear || !armed) begin
                lead_q   <= '0;
                sleep_ok <= 1'b0;
            end else if (tick && lead_q < LW'(LEAD_TICKS)) begin
                lead_q <= lead_q + LW'(1);
                if (lead_q + LW'(1) == LW'(LEAD_TICKS))
                    sleep_ok <= 1'b1;
            end
            if (enter_sleep && armed && !sleep_ok)
                lead_violation <= 1'b1;
        end
    end
endmodule

// File: rtl/wake_timer.sv
module wake_timer
    import wake_timer_pkg::*;
#(
    parameter int SHORT_TICKS = 5,
    parameter int LONG_TICKS  = 120,
    parameter int LEAD_TICKS  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_arm,
    input  logic [2:0] wr_period,
    input  logic       wr_unit,
    input  logic [1:0] mode,
    input  logic       rtc_tick,
    output logic       wake,
    output logic       armed,
    output logic       sleep_ok,
    output logic       lead_violation
);
    localparam int MAX_PERIOD = (1 << PERIOD_W) - 1;
    localparam int MAX_UNIT   = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CNT_W      = $clog2(MAX_PERIOD * MAX_UNIT + 1);

    logic             prev_sleep_q;
    logic             in_sleep, in_brownout, enter_sleep, back_active, clear;
    logic             load;
    logic [CNT_W-1:0] load_val;
    wake_cfg_t        wr_cfg;

    always_ff @(posedge clk) begin
        if (rst) prev_sleep_q <= 1'b0;
        else     prev_sleep_q <= is_sleep_type(mode);
    end

    always_comb begin
        in_sleep      = is_sleep_type(mode);
        in_brownout   = (mode == MODE_BROWNOUT);
        enter_sleep   = in_sleep && !prev_sleep_q;
        back_active   = (mode == MODE_ACTIVE) && prev_sleep_q;
        clear         = in_brownout || back_active;
        wr_cfg.period = wr_period;
        wr_cfg.unit   = wr_unit;
    end

    wake_cfg_reg #(
        .SHORT_TICKS(SHORT_TICKS),
        .LONG_TICKS (LONG_TICKS),
        .CNT_W      (CNT_W)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_arm   (wr_arm),
        .arm_allow(!in_brownout),
        .wr_cfg   (wr_cfg),
        .load     (load),
        .load_val (load_val)
    );

    wake_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .load    (load),
        .load_val(load_val),
        .step    (rtc_tick && in_sleep),
        .armed   (armed),
        .wake    (wake)
    );

    wake_lead_guard #(.LEAD_TICKS(LEAD_TICKS)) u_lead (
        .clk           (clk),
        .rst           (rst),
        .clear         (clear),
        .load          (load),
        .armed         (armed),
        .tick          (rtc_tick),
        .enter_sleep   (enter_sleep),
        .sleep_ok      (sleep_ok),
        .lead_violation(lead_violation)
    );
endmodule

// File: rtl/wake_timer_chk.sv
module wake_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       wr_arm,
    input logic [1:0] mode,
    input logic       wake,
    input logic       armed,
    input logic       sleep_ok,
    input logic       lead_violation
);
    assert_wake_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);

    assert_wake_disarms_R6: assert property (@(posedge clk) disable iff (rst)
        wake |-> !armed);

    assert_brownout_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01) |=> (!armed && !wake));

    assert_no_count_active_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |=> !wake);

    assert_ok_needs_arm_R9: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !sleep_ok);

    assert_violation_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (lead_violation && !(wr_en && wr_arm)) |=> lead_violation);
endmodule

bind wake_timer wake_timer_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_arm        (wr_arm),
    .mode          (mode),
    .wake          (wake),
    .armed         (armed),
    .sleep_ok      (sleep_ok),
    .lead_violation(lead_violation)
);

// File: tb/tb_wake_timer.sv
module tb_wake_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_arm = 1'b0, wr_unit = 1'b0;
    logic [2:0] wr_period = 3'd0;
    logic [1:0] mode = 2'b00;
    logic       rtc_tick = 1'b0;
    logic       wake, armed, sleep_ok, lead_violation;

    int total = 0;
    int bad = 0;
    int tick_num = 0;
    int    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    wake_timer #(.SHORT_TICKS(5), .LONG_TICKS(12), .LEAD_TICKS(3)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_arm(wr_arm),
        .wr_period(wr_period), .wr_unit(wr_unit), .mode(mode),
        .rtc_tick(rtc_tick), .wake(wake), .armed(armed),
        .sleep_ok(sleep_ok), .lead_violation(lead_violation)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver side of the scoreboard: wake expected after n more ticks.
    task automatic expect_wake(input string tag, input int n);
        exp_q.push_back(tick_num + n);
        tag_q.push_back(tag);
    endtask

    // Monitor: every wake pulse must match the head of the queue.
    always @(negedge clk) begin
        if (!rst && wake) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R6 unexpected wake: actual tick=%0d expected=none", tick_num);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e != tick_num) begin
                    bad++;
                    $display("FAIL %s wake: actual tick=%0d expected tick=%0d", t, tick_num, e);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk); rtc_tick = 1'b1; tick_num++;
        @(negedge clk); rtc_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic write(input logic arm, input logic [2:0] p, input logic u);
        @(negedge clk); wr_en = 1'b1; wr_arm = arm; wr_period = p; wr_unit = u;
        @(negedge clk); wr_en = 1'b0; wr_arm = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); mode = m;
        @(negedge clk);
    endtask

    task automatic drained(input string tag);
        chk({tag, " pending wakes"}, exp_q.size(), 0);
    endtask

    initial begin : watchdog
        #1_500_000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 armed", armed, 0);
        chk("R1 wake", wake, 0);
        chk("R1 sleep_ok", sleep_ok, 0);
        chk("R1 lead_violation", lead_violation, 0);

        // R2: arm uses reset values (period 1, short) = 5 ticks, not 5*12
        write(1'b1, 3'd5, 1'b1);
        chk("R2 armed", armed, 1);
        ticks(2);
        chk("R9 sleep_ok early", sleep_ok, 0);
        tick();   // R4: these ticks in active mode do not count
        chk("R9 sleep_ok after lead", sleep_ok, 1);
        set_mode(2'b10);
        chk("R10 no violation", lead_violation, 0);
        expect_wake("R2", 5);
        ticks(4);
        chk("R4 still armed", armed, 1);
        tick();
        chk("R6 disarmed after wake", armed, 0);
        ticks(3);
        drained("R6");
        chk("R9 sleep_ok low after expiry", sleep_ok, 0);

        // R3: long unit, display-only mode, 5*12 = 60 ticks
        set_mode(2'b00);
        write(1'b1, 3'd5, 1'b1);
        ticks(3);
        set_mode(2'b11);
        expect_wake("R3 long", 60);
        ticks(62);
        drained("R3 long");

        // R8: 7 * short = 35 ticks, interrupted by return to active
        set_mode(2'b00);
        write(1'b0, 3'd7, 1'b0);
        write(1'b1, 3'd7, 1'b0);
        ticks(3);
        set_mode(2'b10);
        ticks(10);
        set_mode(2'b00);
        chk("R8 disarmed on return", armed, 0);
        set_mode(2'b10);
        ticks(30);
        chk("R8 no wake after clear", armed, 0);

        // R3 full short range: 35 ticks uninterrupted
        set_mode(2'b00);
        write(1'b1, 3'd7, 1'b0);
        ticks(3);
        set_mode(2'b10);
        expect_wake("R3 short", 35);
        ticks(36);
        drained("R3 short");

        // R5: period 0 wakes on first sleep tick
        set_mode(2'b00);
        write(1'b0, 3'd0, 1'b0);
        write(1'b1, 3'd0, 1'b0);
        ticks(3);
        set_mode(2'b10);
        expect_wake("R5", 1);
        tick();
        drained("R5");

        // R7: brownout disarms and blocks arming
        set_mode(2'b00);
        write(1'b0, 3'd2, 1'b0);
        write(1'b1, 3'd2, 1'b0);
        chk("R7 armed before brownout", armed, 1);
        set_mode(2'b01);
        chk("R7 disarmed in brownout", armed, 0);
        write(1'b1, 3'd2, 1'b0);
        chk("R7 arm ignored", armed, 0);

        // R10: enter sleep one tick after arm -> violation
        set_mode(2'b00);
        write(1'b1, 3'd2, 1'b0);
        tick();
        set_mode(2'b10);
        chk("R10 violation set", lead_violation, 1);
        chk("R10 sleep_ok low", sleep_ok, 0);
        ticks(4);
        chk("R10 violation sticky", lead_violation, 1);
        // R11: re-arm while asleep reloads 10 ticks and clears violation
        write(1'b1, 3'd2, 1'b0);
        chk("R11 violation cleared", lead_violation, 0);
        chk("R11 armed", armed, 1);
        expect_wake("R11", 10);
        ticks(9);
        chk("R11 not yet expired", armed, 1);
        tick();
        drained("R11");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule